// File: doc/BRIEF.md
# Condition Evaluator with Set-on-Condition

This block tests one of sixteen 4-bit condition codes against the four status flags of a processor: negative, zero, overflow and carry. The same evaluator serves branch decisions and a set-on-condition operation. That operation produces a byte of all ones when the condition holds and a byte of all zeros when it does not, and it reports how many cycles it costs. An invert input swaps the evaluated result for any code, so skip-style control logic can use the evaluator without a second table.

The block takes the whole 16-bit instruction word and decodes two fields from it. Bits 11:8 hold the condition code. Bits 5:3 hold the addressing mode, and the mode decides the destination. Mode 000 is a data register. Mode 001 marks a decrement-and-branch instruction, which is not a set, so no write is requested. Every other mode is a memory destination. Address generation and the memory bus are handled elsewhere. This block only presents the result byte together with a one-cycle write request.

Top module: `cond_set_unit`

## Requirements
- R1: While `rst` is high and after it is released, `out_valid`, `cond_true`, `wr_req`, `res_byte` and `cost` are all zero until the first accepted request.
- R2: Code 0 always evaluates true and code 1 always evaluates false, whatever the flags (with `invert` low).
- R3: Code 2 is true when C=0 and Z=0. Code 3 is true when C=1 or Z=1. Code 4 is true when C=0. Code 5 is true when C=1. The flags input is packed as {N,Z,V,C} in bits 3..0.
- R4: Codes 6/7 are true for Z=0 and Z=1. Codes 8/9 are true for V=0 and V=1. Codes 10/11 are true for N=0 and N=1.
- R5: Code 12 is true when N equals V. Code 13 is true when N differs from V. Code 14 is true when Z=0 and N equals V. Code 15 is true when Z=1 or N differs from V.
- R6: With `invert` high, `cond_true` is the complement of the value R2 to R5 give, for every code.
- R7: A request with `in_valid` high is sampled on a rising edge. On the next cycle `out_valid` is high for exactly one cycle, and so is `wr_req` for a set. For a set, `res_byte` is 0xFF when `cond_true` is 1 and 0x00 otherwise.
- R8: The condition is taken from opcode bits 11:8. When opcode bits 5:3 equal 001, `wr_req` stays low, `res_byte` is 0x00 and `cost` is 0, while `cond_true` still reports the evaluation.
- R9: For a set, `cost` is 8 when the mode field is neither 000 nor 001. It is 4 for mode 000 when the result is false, and 6 for mode 000 when the result is true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| opcode | input | 16 | Instruction word; bits 11:8 condition, bits 5:3 mode |
| flags | input | 4 | Status flags {N,Z,V,C} |
| invert | input | 1 | Complement the evaluated condition |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| cond_true | output | 1 | Evaluated (and optionally inverted) condition |
| res_byte | output | 8 | Set result, all ones or all zeros |
| cost | output | 4 | Cycle cost of the operation |
| wr_req | output | 1 | One-cycle request to write `res_byte` |

## Verification
On every cycle the assertions check the following: the result byte agrees with the registered condition whenever a write is requested; a decrement-and-branch request never raises a write; the six-cycle cost appears only with a true result; every output pulse traces back to an accepted request; and codes 0 and 1 give their fixed answers. Whether each of the sixteen codes gives the right truth value for each flag pattern cannot be seen by the assertions. The bench shows it by sweeping all codes against all sixteen flag combinations, then adding random opcodes, modes and invert settings. The bench is also the only place that checks the exact cost for each destination and that the strobes fall back to zero in the cycle after a result.

// File: rtl/ccset_pkg.sv
package ccset_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccflags_t;

  typedef enum logic [1:0] {
    DST_REG  = 2'd0,
    DST_MEM  = 2'd1,
    DST_LOOP = 2'd2
  } dst_kind_e;

  localparam int CC_W   = 4;
  localparam int MODE_W = 3;
endpackage

// File: rtl/cc_decode.sv
module cc_decode
  import ccset_pkg::*;
#(
  parameter int OPC_W   = 16,
  parameter int CC_LSB  = 8,
  parameter int MD_LSB  = 3
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [CC_W-1:0]  cond,
  output dst_kind_e        kind
);
  logic [MODE_W-1:0] mode;

  assign cond = opcode[CC_LSB +: CC_W];
  assign mode = opcode[MD_LSB +: MODE_W];

  always_comb begin
    unique case (mode)
      3'b000:  kind = DST_REG;
      3'b001:  kind = DST_LOOP;
      default: kind = DST_MEM;
    endcase
  end
endmodule

// File: rtl/cc_eval.sv
module cc_eval
  import ccset_pkg::*;
(
  input  logic [CC_W-1:0] code,
  input  ccflags_t        fl,
  input  logic            inv,
  output logic            hit
);
  localparam int PAIRS = 1 << (CC_W - 1);

  // Each even code has a base term and the following odd code is its complement.
  logic [PAIRS-1:0] base;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    if (p == 0) begin : g_true
      assign base[p] = 1'b1;
    end else if (p == 1) begin : g_hi
      assign base[p] = ~fl.c & ~fl.z;
    end else if (p == 2) begin : g_cc
      assign base[p] = ~fl.c;
    end else if (p == 3) begin : g_ne
      assign base[p] = ~fl.z;
    end else if (p == 4) begin : g_vc
      assign base[p] = ~fl.v;
    end else if (p == 5) begin : g_pl
      assign base[p] = ~fl.n;
    end else if (p == 6) begin : g_ge
      assign base[p] = ~(fl.n ^ fl.v);
    end else begin : g_gt
      assign base[p] = ~fl.z & ~(fl.n ^ fl.v);
    end
  end

  assign hit = base[code[CC_W-1:1]] ^ code[0] ^ inv;

  always_comb begin
    if (!inv && code == '0) assert (hit) else $error("AST_ALWAYS_TRUE"); // R2
    if (!inv && code == 4'd1) assert (!hit) else $error("AST_ALWAYS_FALSE"); // R2
  end
endmodule

// File: rtl/scc_cost.sv
module scc_cost
  import ccset_pkg::*;
#(
  parameter int COST_W     = 4,
  parameter int COST_MEM   = 8,
  parameter int COST_REG   = 4,
  parameter int COST_EXTRA = 2
) (
  input  dst_kind_e         kind,
  input  logic              hit,
  output logic [COST_W-1:0] cycles
);
  localparam logic [COST_W-1:0] C_MEM = COST_W'(COST_MEM);
  localparam logic [COST_W-1:0] C_REG = COST_W'(COST_REG);
  localparam logic [COST_W-1:0] C_ADD = COST_W'(COST_EXTRA);

  always_comb begin
    unique case (kind)
      DST_REG:  cycles = hit ? C_REG + C_ADD : C_REG;
      DST_MEM:  cycles = C_MEM;
      default:  cycles = '0;
    endcase
  end
endmodule

// File: rtl/cond_set_unit.sv
module cond_set_unit
  import ccset_pkg::*;
#(
  parameter int OPC_W      = 16,
  parameter int DATA_W     = 8,
  parameter int COST_W     = 4,
  parameter int COST_MEM   = 8,
  parameter int COST_REG   = 4,
  parameter int COST_EXTRA = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [3:0]        flags,
  input  logic              invert,
  output logic              out_valid,
  output logic              cond_true,
  output logic [DATA_W-1:0] res_byte,
  output logic [COST_W-1:0] cost,
  output logic              wr_req
);
  localparam logic [COST_W-1:0] C_TRUE_REG = COST_W'(COST_REG + COST_EXTRA);

  logic [CC_W-1:0]   cond;
  dst_kind_e         kind;
  ccflags_t          fl;
  logic              hit;
  logic [COST_W-1:0] cyc;

  assign fl = ccflags_t'(flags);

  cc_decode #(.OPC_W(OPC_W)) u_dec (
    .opcode (opcode),
    .cond   (cond),
    .kind   (kind)
  );

  cc_eval u_eval (
    .code (cond),
    .fl   (fl),
    .inv  (invert),
    .hit  (hit)
  );

  scc_cost #(
    .COST_W     (COST_W),
    .COST_MEM   (COST_MEM),
    .COST_REG   (COST_REG),
    .COST_EXTRA (COST_EXTRA)
  ) u_cost (
    .kind   (kind),
    .hit    (hit),
    .cycles (cyc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cond_true <= 1'b0;
      res_byte  <= '0;
      cost      <= '0;
      wr_req    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_req    <= in_valid && (kind != DST_LOOP);
      if (in_valid) begin
        cond_true <= hit;
        cost      <= cyc;
        res_byte  <= (kind != DST_LOOP && hit) ? '1 : '0;
      end
    end
  end

  AST_BYTE_MATCH: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (res_byte == (cond_true ? {DATA_W{1'b1}} : {DATA_W{1'b0}}))); // R7

  AST_LOOP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(opcode[5:3]) == 3'b001) |-> !wr_req); // R8

  AST_EXTRA_ONLY_TRUE: assert property (@(posedge clk) disable iff (rst)
    (wr_req && cost == C_TRUE_REG) |-> cond_true); // R9

  AST_PULSE_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R7

  AST_WRITE_IS_RESULT: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> out_valid); // R7
endmodule

// File: tb/tb_cond_set_unit.sv
module tb_cond_set_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] opcode;
  logic [3:0]  flags;
  logic        invert;
  logic        out_valid;
  logic        cond_true;
  logic [7:0]  res_byte;
  logic [3:0]  cost;
  logic        wr_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cond_set_unit dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .flags     (flags),
    .invert    (invert),
    .out_valid (out_valid),
    .cond_true (cond_true),
    .res_byte  (res_byte),
    .cost      (cost),
    .wr_req    (wr_req)
  );

  function automatic bit ref_cond(input logic [3:0] cc, input logic [3:0] f, input bit inv);
    bit n, z, v, c, r;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (cc)
      4'd0:  r = 1'b1;
      4'd1:  r = 1'b0;
      4'd2:  r = !c && !z;
      4'd3:  r = c || z;
      4'd4:  r = !c;
      4'd5:  r = c;
      4'd6:  r = !z;
      4'd7:  r = z;
      4'd8:  r = !v;
      4'd9:  r = v;
      4'd10: r = !n;
      4'd11: r = n;
      4'd12: r = (n == v);
      4'd13: r = (n != v);
      4'd14: r = !z && (n == v);
      default: r = z || (n != v);
    endcase
    return r ^ inv;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] cc, input logic [2:0] mode,
                        input logic [3:0] f, input bit inv, input string req);
    bit       e_hit;
    bit       e_wr;
    int       e_cost;
    int       e_byte;
    @(negedge clk);
    opcode   = {4'b0101, cc, 2'b11, mode, 3'($urandom_range(7))};
    flags    = f;
    invert   = inv;
    in_valid = 1'b1;
    e_hit = ref_cond(cc, f, inv);
    e_wr  = (mode != 3'b001);
    if (mode == 3'b001)      e_cost = 0;
    else if (mode == 3'b000) e_cost = e_hit ? 6 : 4;
    else                     e_cost = 8;
    e_byte = (e_wr && e_hit) ? 8'hFF : 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    check(cond_true == e_hit, req, "cond_true", cond_true, e_hit);
    check(out_valid == 1'b1, "R7", "out_valid", out_valid, 1);
    check(wr_req == e_wr, e_wr ? "R7" : "R8", "wr_req", wr_req, e_wr);
    check(res_byte == e_byte, e_wr ? "R7" : "R8", "res_byte", res_byte, e_byte);
    check(cost == e_cost, e_wr ? "R9" : "R8", "cost", cost, e_cost);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; opcode = '0; flags = '0; invert = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 0 && wr_req == 0 && cond_true == 0 && res_byte == 0 && cost == 0,
          "R1", "outputs in reset", {out_valid, wr_req, cond_true}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 0 && wr_req == 0 && res_byte == 0 && cost == 0,
          "R1", "outputs after reset", {out_valid, wr_req}, 0);

    // Full sweep: every code against every flag pattern, register destination.
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        string rq;
        if (cc < 2)       rq = "R2";
        else if (cc < 6)  rq = "R3";
        else if (cc < 12) rq = "R4";
        else              rq = "R5";
        run_op(4'(cc), 3'b000, 4'(f), 1'b0, rq);
      end
    end

    // Invert on every code.
    for (int cc = 0; cc < 16; cc++) run_op(4'(cc), 3'b010, 4'(cc), 1'b1, "R6");

    // Directed corners: always-true on register costs 6, memory costs 8, loop mode.
    run_op(4'd0, 3'b000, 4'h0, 1'b0, "R9");
    run_op(4'd1, 3'b000, 4'hF, 1'b0, "R9");
    run_op(4'd0, 3'b111, 4'h0, 1'b0, "R9");
    run_op(4'd0, 3'b001, 4'h0, 1'b0, "R8");
    run_op(4'd14, 3'b001, 4'b1010, 1'b0, "R8");

    // Strobe is a single cycle.
    @(negedge clk);
    check(out_valid == 0 && wr_req == 0, "R7", "strobe width", {out_valid, wr_req}, 0);

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      run_op(4'($urandom_range(15)), 3'($urandom_range(7)), 4'($urandom_range(15)),
             1'($urandom_range(1)), "R6");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule